// File: doc/BRIEF.md
# ACPI Power-Management Event and Timer Block

This block holds the two 16-bit power-management event registers, a status register and an enable register, and a free-running power-management counter. It drives one level-sensitive system control interrupt (SCI). The status bits are set by hardware events and cleared by software. The enable register decides which of those status bits may raise the interrupt.

Software reaches the block through a one-cycle register bus into a 12-byte window. A read returns its data combinationally in the cycle it is presented. A write takes effect at the next clock edge, and each byte is gated by its own byte enable. The counter advances once in every cycle in which `tick_en` is high. The surrounding logic pulses `tick_en` at the nominal 3.579545 MHz rate.

Each time the counter's top bit changes value, in either direction, the timer status bit is set. Power-button and global-event pulses set their own status bits.

Top module: `pm_event_timer`

## Requirements
- R1: On reset, the status register, the enable register and the counter are all 0, and `sci` is low.
- R2: The offset map is fixed. Offsets 0–1 hold the status register, low byte first. Offsets 2–3 hold the enable register, low byte first. Offsets 4–7 are reserved: they read as 0 and ignore writes. Offset 8 holds the counter. The access size code is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. Data lane k, bits 8k+7..8k, carries the byte at offset `bus_addr`+k. Lanes that would reach past offset 3 in the status/enable group read as 0 and their write data is dropped.
- R3: A read of the status/enable group returns the current register bytes. A 4-byte read at offset 8 returns the counter, zero-extended to 32 bits. When no read is in progress, `bus_rdata` is 0.
- R4: A write to an enable byte whose lane enable is set replaces that whole byte with the written value.
- R5: A write to a status byte whose lane enable is set clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R6: A `pwrbtn_evt` pulse sets status bit 5, and a `gbl_evt` pulse sets status bit 8. When a set falls in the same cycle as a software clear of that bit, the set wins.
- R7: The counter increases by 1 at each edge where `tick_en` is high, holds otherwise, and wraps modulo 2^`TMR_W` (`TMR_W` is 32 by default).
- R8: Any change of the counter's top bit, whether 0 to 1 or 1 to 0, sets status bit 0 at the same edge. When a software clear falls in the same cycle, the set wins.
- R9: `sci` is high exactly when (enable AND status) has a 1 in bit 0, 5 or 8. It follows every register update at the edge that makes the update.
- R10: `bus_err` is high in the cycle of any selected access that uses size code 3, starts at offset 9–15, or reaches offset 8 with a size other than 4 bytes. Such an access changes no register and reads as 0.
- R11: A write to the counter is ignored, and the counter keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset inside the window |
| bus_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal |
| bus_be | input | 4 | Per-lane write byte enables |
| bus_wdata | input | 32 | Write data, lane k for offset addr+k |
| bus_rdata | output | 32 | Read data, same lane mapping |
| bus_err | output | 1 | Illegal access in this cycle |
| tick_en | input | 1 | Counter advance qualifier |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| gbl_evt | input | 1 | Global event pulse |
| sci | output | 1 | Level system control interrupt |

## Verification
The assertions place no constraint on when event pulses or counter ticks arrive. They do assume that the bus fields are known whenever `bus_sel` is high, and that each access lasts exactly one cycle. The stimulus changes every input only on the falling clock edge and holds it for one full cycle.

The bench builds the counter with a narrow `TMR_W` so that top-bit changes in both directions, and the wrap itself, are reached within the run. It also lines up a software clear with a top-bit change, and with an event pulse, in the same cycle.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

  localparam int EVT_BYTES = 4;
  localparam int TMR_OFS   = 8;
  localparam int RSV_LO    = 4;
  localparam int WIN_BYTES = 12;

  localparam int BIT_TMR = 0;
  localparam int BIT_PWR = 5;
  localparam int BIT_GBL = 8;
  localparam logic [15:0] SCI_SRC_MASK =
    16'((1 << BIT_TMR) | (1 << BIT_PWR) | (1 << BIT_GBL));

  typedef enum logic [1:0] {
    SZ_B1  = 2'd0,
    SZ_B2  = 2'd1,
    SZ_B4  = 2'd2,
    SZ_BAD = 2'd3
  } acc_size_e;

  // bytes moved by an access of the given size code
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_B1:   return 3'd1;
      SZ_B2:   return 3'd2;
      SZ_B4:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // gather lanes of a read from the status/enable group
  function automatic logic [31:0] evt_read(input logic [31:0] regs,
                                           input logic [1:0]  ofs,
                                           input logic [2:0]  n);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < EVT_BYTES; k++) begin
      if (k < int'(n) && int'(ofs) + k < EVT_BYTES)
        r[8*k +: 8] = regs[8*(int'(ofs) + k) +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/pm_bus_decode.sv
module pm_bus_decode
  import pm_evt_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic [3:0]    be,
  input  logic [31:0]   wdata,
  output logic          acc_err,
  output logic          evt_grp,
  output logic          tmr_grp,
  output logic [3:0]    evt_we,
  output logic [31:0]   evt_wd
);

  localparam logic [AW-1:0] A_RSV = AW'(RSV_LO);
  localparam logic [AW-1:0] A_TMR = AW'(TMR_OFS);
  localparam logic [AW-1:0] A_EVT = AW'(EVT_BYTES);

  logic [2:0] nbytes;
  logic       legal_sz;
  logic       rsv_grp;

  always_comb begin
    nbytes   = size_bytes(size);
    legal_sz = (size != SZ_BAD);
    evt_grp  = sel && legal_sz && (addr < A_EVT);
    rsv_grp  = sel && legal_sz && (addr >= A_RSV) && (addr < A_TMR);
    tmr_grp  = sel && (addr == A_TMR) && (size == SZ_B4);
    acc_err  = sel && !(evt_grp || rsv_grp || tmr_grp);
  end

  // route each register byte j to the lane that carries it
  for (genvar j = 0; j < EVT_BYTES; j++) begin : g_byte
    logic [AW-1:0] lane;
    assign lane = AW'(j) - addr;
    assign evt_we[j] = evt_grp && wr && (AW'(j) >= addr) &&
                       (int'(lane) < int'(nbytes)) && be[lane[1:0]];
    assign evt_wd[8*j +: 8] = wdata[8*lane[1:0] +: 8];
  end

endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  evt_we,
  input  logic [31:0] evt_wd,
  input  logic [15:0] set_vec,
  output logic [15:0] sts_q,
  output logic [15:0] en_q
);

  logic [15:0] clr_vec;
  logic [15:0] sts_d;
  logic [15:0] en_d;

  always_comb begin
    clr_vec = '0;
    en_d    = en_q;
    for (int j = 0; j < 2; j++) begin
      if (evt_we[j])     clr_vec[8*j +: 8] = evt_wd[8*j +: 8];
      if (evt_we[j + 2]) en_d[8*j +: 8]    = evt_wd[16 + 8*j +: 8];
    end
    // hardware set dominates a same-cycle software clear
    sts_d = (sts_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
    end
  end

endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  output logic [W-1:0] cnt_q,
  output logic         msb_flip
);

  function automatic logic [W-1:0] step(input logic [W-1:0] cur,
                                        input logic         inc);
    return cur + W'(inc);
  endfunction

  logic [W-1:0] cnt_d;

  assign cnt_d    = step(cnt_q, tick_en);
  assign msb_flip = cnt_d[W-1] ^ cnt_q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pm_event_timer.sv
module pm_event_timer
  import pm_evt_pkg::*;
#(
  parameter int TMR_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [1:0]  bus_size,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_err,
  input  logic        tick_en,
  input  logic        pwrbtn_evt,
  input  logic        gbl_evt,
  output logic        sci
);

  localparam int AW = $clog2(WIN_BYTES);

  logic             evt_grp;
  logic             tmr_grp;
  logic [3:0]       evt_we;
  logic [31:0]      evt_wd;
  logic [15:0]      set_vec;
  logic [15:0]      sts_q;
  logic [15:0]      en_q;
  logic [TMR_W-1:0] cnt_q;
  logic             tmr_flip;

  pm_bus_decode #(.AW(AW)) u_dec (
    .sel     (bus_sel),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .size    (bus_size),
    .be      (bus_be),
    .wdata   (bus_wdata),
    .acc_err (bus_err),
    .evt_grp (evt_grp),
    .tmr_grp (tmr_grp),
    .evt_we  (evt_we),
    .evt_wd  (evt_wd)
  );

  pm_timer #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .cnt_q    (cnt_q),
    .msb_flip (tmr_flip)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[BIT_TMR] = tmr_flip;
    set_vec[BIT_PWR] = pwrbtn_evt;
    set_vec[BIT_GBL] = gbl_evt;
  end

  pm_evt_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_we  (evt_we),
    .evt_wd  (evt_wd),
    .set_vec (set_vec),
    .sts_q   (sts_q),
    .en_q    (en_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (evt_grp)      bus_rdata = evt_read({en_q, sts_q}, bus_addr[1:0], size_bytes(bus_size));
      else if (tmr_grp) bus_rdata = 32'(cnt_q);
    end
  end

  assign sci = |(en_q & sts_q & SCI_SRC_MASK);

endmodule

// File: rtl/pm_event_timer_chk.sv
module pm_event_timer_chk #(
  parameter int TMR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [31:0]      bus_rdata,
  input logic             bus_err,
  input logic             tick_en,
  input logic             pwrbtn_evt,
  input logic             gbl_evt,
  input logic             sci,
  input logic [15:0]      sts_q,
  input logic [15:0]      en_q,
  input logic [TMR_W-1:0] cnt_q,
  input logic             tmr_flip
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (sts_q == 16'd0 && en_q == 16'd0 && cnt_q == '0 && !sci));

  assert_pwr_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwrbtn_evt |=> sts_q[5]);

  assert_gbl_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gbl_evt |=> sts_q[8]);

  assert_tick_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> cnt_q == TMR_W'($past(cnt_q) + 1'b1));

  assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));

  assert_flip_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_flip |=> sts_q[0]);

  assert_sci_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sci) |-> $past(bus_sel && bus_wr));

  assert_err_needs_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> !bus_err);

  assert_err_rd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_rdata == 32'd0);

  assert_err_no_en_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_err) |=> $stable(en_q));

endmodule

bind pm_event_timer pm_event_timer_chk #(.TMR_W(TMR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_rdata  (bus_rdata),
  .bus_err    (bus_err),
  .tick_en    (tick_en),
  .pwrbtn_evt (pwrbtn_evt),
  .gbl_evt    (gbl_evt),
  .sci        (sci),
  .sts_q      (sts_q),
  .en_q       (en_q),
  .cnt_q      (cnt_q),
  .tmr_flip   (tmr_flip)
);

// File: tb/pm_event_timer_bench.sv
module pm_event_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TW = 10;
  localparam longint TMASK = (64'd1 << TW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        tick_en = 1'b0, pwrbtn_evt = 1'b0, gbl_evt = 1'b0;
  logic        sci;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state: low half status, high half enable
  longint m_evt = 0;
  longint m_tmr = 0;
  logic [31:0] last_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_event_timer #(.TMR_W(TW)) u_pm_event_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .tick_en(tick_en), .pwrbtn_evt(pwrbtn_evt), .gbl_evt(gbl_evt), .sci(sci)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int nb(input logic [1:0] z);
    return (z == 2'd0) ? 1 : (z == 2'd1) ? 2 : (z == 2'd2) ? 4 : 0;
  endfunction

  function automatic bit model_err(input logic [3:0] a, input logic [1:0] z);
    return (z == 2'd3) || (int'(a) >= 9) || (int'(a) == 8 && z != 2'd2);
  endfunction

  // one bus cycle: drive after falling edge, compare, then advance model
  task automatic cyc(input logic s, input logic w, input logic [3:0] a,
                     input logic [1:0] z, input logic [31:0] d, input logic [3:0] b,
                     input logic t, input logic p, input logic g, input string tag);
    bit     e;
    longint exp_rd, nt;
    bus_sel = s; bus_wr = w; bus_addr = a; bus_size = z; bus_wdata = d;
    bus_be = b; tick_en = t; pwrbtn_evt = p; gbl_evt = g;
    #1;
    e = s && model_err(a, z);
    exp_rd = 0;
    if (s && !w && !e) begin
      if (int'(a) == 8) exp_rd = m_tmr;
      else if (int'(a) < 4)
        for (int k = 0; k < nb(z); k++)
          if (int'(a) + k < 4) exp_rd |= ((m_evt >> (8*(int'(a)+k))) & 255) << (8*k);
    end
    check(bus_err == e, tag, "bus_err", longint'(bus_err), longint'(e));
    check(bus_rdata == exp_rd[31:0], tag, "bus_rdata", longint'(bus_rdata), exp_rd);
    check(sci == (((m_evt & (m_evt >> 16)) & 'h121) != 0), tag, "sci",
          longint'(sci), longint'(((m_evt & (m_evt >> 16)) & 'h121) != 0));
    last_rd = bus_rdata;
    @(posedge clk);
    nt = t ? ((m_tmr + 1) & TMASK) : m_tmr;
    if (s && w && !e && int'(a) < 4)
      for (int k = 0; k < nb(z); k++) begin
        int off = int'(a) + k;
        longint byt = (longint'(d) >> (8*k)) & 255;
        if (off < 4 && b[k]) begin
          if (off < 2) m_evt &= ~(byt << (8*off));
          else m_evt = (m_evt & ~(longint'(255) << (8*off))) | (byt << (8*off));
        end
      end
    if (((nt ^ m_tmr) >> (TW-1)) & 1) m_evt |= 1;
    if (p) m_evt |= 1 << 5;
    if (g) m_evt |= 1 << 8;
    m_tmr = nt;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] z, input string tag);
    cyc(1, 0, a, z, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] z, input logic [31:0] d,
                    input logic [3:0] b, input string tag);
    cyc(1, 1, a, z, d, b, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sci == 1'b0, "R1", "sci in reset", longint'(sci), 0);
    rst_n = 1'b1;
    // R1 reset values
    rd(0, 2, "R1"); check(last_rd == 0, "R1", "evt after reset", last_rd, 0);
    rd(8, 2, "R1"); check(last_rd == 0, "R1", "timer after reset", last_rd, 0);
    // R4 enable writes, byte enables
    wr(2, 1, 32'h0000_0121, 4'b0011, "R4");
    rd(2, 1, "R4"); check(last_rd == 32'h121, "R4", "enable", last_rd, 'h121);
    wr(3, 0, 32'h0000_00FF, 4'b0000, "R4");
    rd(2, 1, "R4"); check(last_rd == 32'h121, "R4", "be masked", last_rd, 'h121);
    wr(0, 2, 32'h00A5_0000, 4'b0100, "R4");
    rd(3, 0, "R4"); check(last_rd == 32'h1, "R4", "byte3 kept", last_rd, 1);
    rd(2, 0, "R4"); check(last_rd == 32'hA5, "R4", "byte2 replaced", last_rd, 'hA5);
    wr(2, 1, 32'h0000_0121, 4'b0011, "R4");
    // R2/R3 offsets and widths
    rd(1, 1, "R2"); check(last_rd == 32'h2100, "R2", "offset1 two bytes", last_rd, 'h2100);
    rd(2, 2, "R2"); check(last_rd == 32'h0121, "R2", "past offset3 zero", last_rd, 'h121);
    rd(4, 2, "R2"); rd(6, 1, "R2");
    wr(4, 2, 32'hFFFF_FFFF, 4'hF, "R2");
    rd(0, 2, "R3");
    // R6 power button with SCI, R5 W1C, R9
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "R6");
    check(sci == 1'b1, "R9", "sci on pwr", longint'(sci), 1);
    rd(0, 0, "R6"); check(last_rd == 32'h20, "R6", "pwr status", last_rd, 'h20);
    wr(0, 0, 32'h0000_00DF, 4'b0001, "R5");
    rd(0, 0, "R5"); check(last_rd == 32'h20, "R5", "zeros keep", last_rd, 'h20);
    wr(0, 0, 32'h0000_0020, 4'b0001, "R5");
    check(sci == 1'b0, "R9", "sci after clear", longint'(sci), 0);
    // R6 set beats clear, global event
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R6");
    cyc(1, 1, 1, 0, 32'h1, 4'b0001, 0, 0, 1, "R6");
    rd(1, 0, "R6"); check(last_rd == 32'h1, "R6", "set over clear", last_rd, 1);
    wr(0, 1, 32'h0100, 4'b0010, "R5");
    rd(0, 1, "R5"); check(last_rd == 32'h0, "R5", "gbl cleared", last_rd, 0);
    // R10 errors
    wr(2, 3, 32'h0, 4'hF, "R10");
    rd(2, 1, "R10"); check(last_rd == 32'h121, "R10", "bad size no write", last_rd, 'h121);
    rd(8, 1, "R10"); rd(9, 2, "R10"); rd(13, 0, "R10");
    // R7 counting, R11 writes ignored
    for (int i = 0; i < 100; i++) cyc(0, 0, 0, 0, 0, 0, i % 3 != 0, 0, 0, "R7");
    wr(8, 2, 32'h0000_0300, 4'hF, "R11");
    rd(8, 2, "R11"); check(last_rd == 32'd66, "R11", "timer after write", last_rd, 66);
    // R8 rising toggle
    while (m_tmr != 511) cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, "R8");
    rd(0, 0, "R8"); check(last_rd == 32'h1, "R8", "rise sets", last_rd, 1);
    check(sci == 1'b1, "R9", "sci on timer", longint'(sci), 1);
    wr(0, 0, 32'h1, 4'b0001, "R8");
    // R8 falling toggle on wrap, with same-cycle clear
    while (m_tmr != TMASK) cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, "R7");
    cyc(1, 1, 0, 0, 32'h1, 4'b0001, 1, 0, 0, "R8");
    rd(8, 2, "R7"); check(last_rd == 32'd0, "R7", "wrap", last_rd, 0);
    rd(0, 0, "R8"); check(last_rd == 32'h1, "R8", "wrap set beats clear", last_rd, 1);
    wr(0, 2, 32'h0000_FFFF, 4'b0011, "R5");
    check(sci == 1'b0, "R9", "sci final", longint'(sci), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule